// File: doc/BRIEF.md
# Indirect-Addressed Serial Configuration Port

This block is the slave side of a four-wire serial port that configures a data-converter control block. A host frames each access with an active-high select, toggles a serial clock that idles high and shifts 16-bit words in MSB first. The serial inputs are brought into the system-clock domain through synchronizers, and every register lives on the system clock.

One primary configuration word is written directly. Four secondary words are reached only through a 4-bit address field in the low bits of that configuration word: two reference-DAC words, a sequencer word and a reference-routing word. A configuration write whose address field names a secondary write makes the next complete frame land in that register. One that names a read makes the next frame shift that register's contents out on the data output. A further address code issues a software reset. Update-control bits [13:12] of the configuration word select a full update, an update of the channel bits [15:14] only, or no action.

All five registers are presented in parallel on the outputs, together with a one-cycle software-reset pulse.

Top module: `cvcfg_port`

## Requirements
- R1: After reset the configuration, sequencer and routing registers read 0x0000, both DAC registers read 0x07FF, and the data output is 0.
- R2: A complete frame shifts 16 bits MSB first, sampling on each serial-clock falling edge. With bits [13:12] = 01 and address bits [3:0] in {0000, 1000, 0111, 1111}, the whole word is stored in the configuration register once the serial-clock rising edge that follows the 16th falling edge has been seen.
- R3: A configuration word with bits [13:12] = 00 or 11 changes only configuration bits [15:14] and starts no access.
- R4: A configuration word with bits [13:12] = 10 changes no register and starts no access.
- R5: A frame whose select drops before the rising edge that follows the 16th falling edge changes no register and leaves any pending write target in place.
- R6: With a full update, address 0010 or 1010 sends the next frame to DAC register 1, and 0101 or 1101 sends it to DAC register 2. DAC bits [15:11] are stored as 0.
- R7: With a full update, address 1001 sends the next frame to the sequencer register. Sequencer bits [3:2] are read-only and keep their value (0).
- R8: With a full update, address 1100 sends the next frame to the routing register.
- R9: With a full update, addresses 0001, 0011, 0110, 1011 and 1110 request the configuration, DAC 1, DAC 2, sequencer and routing register. The next frame shifts the requested value out MSB first, one bit valid before each falling edge. A frame with no pending request shifts out zeros.
- R10: A data frame sent to a secondary register leaves the configuration register unchanged, and the frame after it is decoded as a configuration word again.
- R11: With a full update, address 0100 raises the software-reset output for exactly one system-clock cycle. In the following cycle every register is back at its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, idles high, data sampled on falling edge |
| ser_sel | input | 1 | Active-high frame select |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_dout | output | 1 | Serial read-back data, MSB first |
| cfg_o | output | 16 | Configuration register |
| dac1_o | output | 16 | Reference DAC 1 register |
| dac2_o | output | 16 | Reference DAC 2 register |
| seq_o | output | 16 | Sequencer register |
| route_o | output | 16 | Reference-routing register |
| soft_rst_o | output | 1 | One-cycle software-reset pulse |

## Verification
A wrong pending-target state has no effect while it is set. It shows up only at the end of the next complete frame: a secondary register changes when it should not, or the configuration register takes the data word instead of the intended register. A stale or missing read request shows up within one frame, as a wrong bit on the data output, starting from the MSB. A bit counter that is out of step shows up in the same frame, as a shifted stored word or a commit that never happens. A late software reset shows up as an extra pulse cycle, or as registers that are not yet at reset values one cycle after the pulse.

// File: rtl/cvcfg_pkg.sv
package cvcfg_pkg;

  localparam int CH_HI   = 15;
  localparam int CH_LO   = 14;
  localparam int UPD_HI  = 13;
  localparam int UPD_LO  = 12;
  localparam int ADDR_W  = 4;
  localparam int DAC_USED = 11;
  localparam int SEQ_RO_HI = 3;
  localparam int SEQ_RO_LO = 2;

  typedef enum logic [2:0] {
    TGT_CFG   = 3'd0,
    TGT_DAC1  = 3'd1,
    TGT_DAC2  = 3'd2,
    TGT_SEQ   = 3'd3,
    TGT_ROUTE = 3'd4
  } tgt_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_RST  = 2'd3
  } op_e;

  typedef struct packed {
    op_e  op;
    tgt_e tgt;
  } acc_t;

  function automatic acc_t addr_decode(input logic [ADDR_W-1:0] a);
    acc_t r;
    r.op  = OP_NONE;
    r.tgt = TGT_CFG;
    case (a)
      4'b0001: begin r.op = OP_RD;  r.tgt = TGT_CFG;   end
      4'b0011: begin r.op = OP_RD;  r.tgt = TGT_DAC1;  end
      4'b0110: begin r.op = OP_RD;  r.tgt = TGT_DAC2;  end
      4'b1011: begin r.op = OP_RD;  r.tgt = TGT_SEQ;   end
      4'b1110: begin r.op = OP_RD;  r.tgt = TGT_ROUTE; end
      4'b0010, 4'b1010: begin r.op = OP_WR; r.tgt = TGT_DAC1; end
      4'b0101, 4'b1101: begin r.op = OP_WR; r.tgt = TGT_DAC2; end
      4'b1001: begin r.op = OP_WR;  r.tgt = TGT_SEQ;   end
      4'b1100: begin r.op = OP_WR;  r.tgt = TGT_ROUTE; end
      4'b0100: begin r.op = OP_RST; r.tgt = TGT_CFG;   end
      default: begin r.op = OP_NONE; r.tgt = TGT_CFG;  end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cvcfg_rx.sv
module cvcfg_rx #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         sel_i,
  input  logic         din_i,
  output logic         frame_start_o,
  output logic         fall_o,
  output logic         word_vld_o,
  output logic [W-1:0] word_o
);
  localparam int CW = $clog2(W + 1);

  logic [SYNC-1:0] sclk_sy, sel_sy, din_sy;
  logic            sclk_d, sel_d;
  logic            sclk_s, sel_s, din_s;
  logic [CW-1:0]   cnt;
  logic            done;
  logic            fall, rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sy <= '1;
      sel_sy  <= '0;
      din_sy  <= '0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC-2:0], sclk_i};
      sel_sy  <= {sel_sy[SYNC-2:0], sel_i};
      din_sy  <= {din_sy[SYNC-2:0], din_i};
    end
  end

  assign sclk_s = sclk_sy[SYNC-1];
  assign sel_s  = sel_sy[SYNC-1];
  assign din_s  = din_sy[SYNC-1];
  assign fall   = sel_s & sclk_d & ~sclk_s;
  assign rise   = sel_s & ~sclk_d & sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d        <= 1'b1;
      sel_d         <= 1'b0;
      cnt           <= '0;
      done          <= 1'b0;
      word_o        <= '0;
      word_vld_o    <= 1'b0;
      frame_start_o <= 1'b0;
      fall_o        <= 1'b0;
    end else begin
      sclk_d        <= sclk_s;
      sel_d         <= sel_s;
      word_vld_o    <= 1'b0;
      frame_start_o <= sel_s & ~sel_d;
      fall_o        <= fall;
      if (!sel_s) begin
        cnt  <= '0;
        done <= 1'b0;
      end else begin
        if (fall && cnt < CW'(W)) begin
          word_o <= {word_o[W-2:0], din_s};
          cnt    <= cnt + 1'b1;
        end
        if (rise && cnt == CW'(W) && !done) begin
          word_vld_o <= 1'b1;
          done       <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cvcfg_tx.sv
module cvcfg_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         shift_i,
  output logic         dout_o
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)          sh <= '0;
    else if (load_i)  sh <= load_data_i;
    else if (shift_i) sh <= {sh[W-2:0], 1'b0};
  end

  assign dout_o = sh[W-1];

endmodule

// File: rtl/cvcfg_bank.sv
module cvcfg_bank
  import cvcfg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_start_i,
  input  logic         word_vld_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] cfg_o,
  output logic [W-1:0] dac1_o,
  output logic [W-1:0] dac2_o,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] route_o,
  output logic         soft_rst_o,
  output logic         expect_cfg_o,
  output logic [W-1:0] rd_data_o
);
  localparam logic [W-1:0] DAC_RST  = W'((1 << DAC_USED) - 1);
  localparam logic [W-1:0] DAC_MASK = W'((1 << DAC_USED) - 1);
  localparam logic [W-1:0] SEQ_RO   = W'(((1 << (SEQ_RO_HI - SEQ_RO_LO + 1)) - 1) << SEQ_RO_LO);

  tgt_e         wr_tgt, rd_tgt;
  logic         rd_pend;
  acc_t         acc;
  logic [1:0]   upd;
  logic [W-1:0] rd_mux;

  assign acc = addr_decode(word_i[ADDR_W-1:0]);
  assign upd = word_i[UPD_HI:UPD_LO];

  always_comb begin
    case (rd_tgt)
      TGT_DAC1:  rd_mux = dac1_o;
      TGT_DAC2:  rd_mux = dac2_o;
      TGT_SEQ:   rd_mux = seq_o;
      TGT_ROUTE: rd_mux = route_o;
      default:   rd_mux = cfg_o;
    endcase
  end

  assign rd_data_o    = rd_pend ? rd_mux : '0;
  assign expect_cfg_o = (wr_tgt == TGT_CFG);

  always_ff @(posedge clk) begin
    if (rst || soft_rst_o) begin
      cfg_o      <= '0;
      dac1_o     <= DAC_RST;
      dac2_o     <= DAC_RST;
      seq_o      <= '0;
      route_o    <= '0;
      wr_tgt     <= TGT_CFG;
      rd_tgt     <= TGT_CFG;
      rd_pend    <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      if (frame_start_i) rd_pend <= 1'b0;
      if (word_vld_i) begin
        if (wr_tgt != TGT_CFG) begin
          case (wr_tgt)
            TGT_DAC1:  dac1_o  <= word_i & DAC_MASK;
            TGT_DAC2:  dac2_o  <= word_i & DAC_MASK;
            TGT_SEQ:   seq_o   <= (word_i & ~SEQ_RO) | (seq_o & SEQ_RO);
            TGT_ROUTE: route_o <= word_i;
            default:   route_o <= route_o;
          endcase
          wr_tgt <= TGT_CFG;
        end else begin
          case (upd)
            2'b01: begin
              cfg_o <= word_i;
              case (acc.op)
                OP_WR:  wr_tgt <= acc.tgt;
                OP_RD: begin
                  rd_tgt  <= acc.tgt;
                  rd_pend <= 1'b1;
                end
                OP_RST: soft_rst_o <= 1'b1;
                default: wr_tgt <= TGT_CFG;
              endcase
            end
            2'b10: cfg_o <= cfg_o;
            default: cfg_o[CH_HI:CH_LO] <= word_i[CH_HI:CH_LO];
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/cvcfg_port.sv
module cvcfg_port #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk,
  input  logic         ser_sel,
  input  logic         ser_din,
  output logic         ser_dout,
  output logic [W-1:0] cfg_o,
  output logic [W-1:0] dac1_o,
  output logic [W-1:0] dac2_o,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] route_o,
  output logic         soft_rst_o
);
  logic         frame_start, fall, word_vld, expect_cfg;
  logic [W-1:0] word, rd_data;

  cvcfg_rx #(.W(W), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst(rst), .sclk_i(ser_clk), .sel_i(ser_sel), .din_i(ser_din),
    .frame_start_o(frame_start), .fall_o(fall), .word_vld_o(word_vld), .word_o(word)
  );

  cvcfg_bank #(.W(W)) u_bank (
    .clk(clk), .rst(rst), .frame_start_i(frame_start), .word_vld_i(word_vld),
    .word_i(word), .cfg_o(cfg_o), .dac1_o(dac1_o), .dac2_o(dac2_o), .seq_o(seq_o),
    .route_o(route_o), .soft_rst_o(soft_rst_o), .expect_cfg_o(expect_cfg),
    .rd_data_o(rd_data)
  );

  cvcfg_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .load_i(frame_start), .load_data_i(rd_data),
    .shift_i(fall), .dout_o(ser_dout)
  );

endmodule

// File: rtl/cvcfg_chk.sv
module cvcfg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         word_vld,
  input logic         expect_cfg,
  input logic [W-1:0] word,
  input logic [W-1:0] cfg_o,
  input logic [W-1:0] dac1_o,
  input logic [W-1:0] dac2_o,
  input logic [W-1:0] seq_o,
  input logic [W-1:0] route_o,
  input logic         soft_rst_o
);
  a_r5_hold_without_word: assert property (@(posedge clk) disable iff (rst)
    (!word_vld && !soft_rst_o) |=> ($stable(cfg_o) && $stable(dac1_o) && $stable(dac2_o)
                                    && $stable(seq_o) && $stable(route_o)));

  a_r3_channel_only: assert property (@(posedge clk) disable iff (rst)
    (word_vld && expect_cfg && (word[13:12] == 2'b00 || word[13:12] == 2'b11))
    |=> (cfg_o[13:0] == $past(cfg_o[13:0]) && cfg_o[15:14] == $past(word[15:14])
         && expect_cfg));

  a_r4_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
    (word_vld && expect_cfg && word[13:12] == 2'b10) |=> ($stable(cfg_o) && expect_cfg));

  a_r10_data_frame: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !expect_cfg) |=> ($stable(cfg_o) && expect_cfg));

  a_r11_pulse_one: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |=> (!soft_rst_o && cfg_o == '0 && dac1_o == W'(16'h07FF)
                    && dac2_o == W'(16'h07FF) && seq_o == '0 && route_o == '0));

  a_r6_dac_reserved: assert property (@(posedge clk) disable iff (rst)
    (dac1_o[15:11] == 5'd0 && dac2_o[15:11] == 5'd0));

  a_r7_seq_readonly: assert property (@(posedge clk) disable iff (rst)
    seq_o[3:2] == 2'd0);

endmodule

bind cvcfg_port cvcfg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .word_vld(word_vld), .expect_cfg(expect_cfg), .word(word),
  .cfg_o(cfg_o), .dac1_o(dac1_o), .dac2_o(dac2_o), .seq_o(seq_o), .route_o(route_o),
  .soft_rst_o(soft_rst_o)
);

// File: tb/sim_cvcfg_port.sv
module sim_cvcfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 6;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b1, ser_sel = 1'b0, ser_din = 1'b0;
  logic ser_dout, soft_rst_o;
  logic [W-1:0] cfg_o, dac1_o, dac2_o, seq_o, route_o;

  int errs = 0;
  int checks = 0;
  int pulse_cnt = 0;

  typedef struct {
    bit           chk;
    logic [W-1:0] exp;
  } rd_item_t;
  rd_item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cvcfg_port u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel(ser_sel), .ser_din(ser_din),
    .ser_dout(ser_dout), .cfg_o(cfg_o), .dac1_o(dac1_o), .dac2_o(dac2_o),
    .seq_o(seq_o), .route_o(route_o), .soft_rst_o(soft_rst_o)
  );

  always @(posedge clk) if (soft_rst_o) pulse_cnt <= pulse_cnt + 1;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits: number of bits clocked; last_rise=0 drops select before the final rising edge
  task automatic frame(input logic [W-1:0] w, input int nbits, input bit last_rise,
                       input bit chk, input logic [W-1:0] exp_rd);
    rd_item_t it;
    it.chk = chk;
    it.exp = exp_rd;
    sbq.push_back(it);
    @(negedge clk);
    ser_sel = 1'b1;
    wait_clk(2*PH);
    for (int i = 0; i < nbits; i++) begin
      ser_din = w[W-1-i];
      wait_clk(PH);
      ser_clk = 1'b0;
      wait_clk(PH);
      if (i != nbits-1 || last_rise) ser_clk = 1'b1;
    end
    wait_clk(PH);
    ser_sel = 1'b0;
    wait_clk(PH);
    ser_clk = 1'b1;
    wait_clk(2*PH);
  endtask

  task automatic wr(input logic [W-1:0] w);
    frame(w, W, 1'b1, 1'b1, '0);
  endtask

  // Monitor: captures the read-back word of each frame and compares with the scoreboard
  initial begin
    forever begin
      logic [W-1:0] cap;
      int nb;
      rd_item_t it;
      @(posedge ser_sel);
      cap = '0;
      nb = 0;
      while (ser_sel) begin
        @(negedge ser_clk or negedge ser_sel);
        if (ser_sel && !ser_clk) begin
          cap = {cap[W-2:0], ser_dout};
          nb++;
        end
      end
      if (sbq.size() == 0) begin
        checks++; errs++;
        $display("FAIL R9: actual=%h expected=<no item>", cap);
      end else begin
        it = sbq.pop_front();
        if (it.chk && nb == W) check("R9 readback", cap, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait_clk(6);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset values
    check("R1 cfg", cfg_o, 16'h0000);
    check("R1 dac1", dac1_o, 16'h07FF);
    check("R1 dac2", dac2_o, 16'h07FF);
    check("R1 seq", seq_o, 16'h0000);
    check("R1 route", route_o, 16'h0000);
    check("R1 dout", {15'd0, ser_dout}, 16'h0000);

    // R2 full update, config-only codes
    wr(16'h1000);
    check("R2 cfg 0000", cfg_o, 16'h1000);
    wr(16'hD0F7);
    check("R2 cfg 0111", cfg_o, 16'hD0F7);
    wr(16'h5A38);
    check("R2 cfg 1000", cfg_o, 16'h5A38);

    // R3 channel-only update
    wr(16'h4FF2);
    check("R3 upd 00", cfg_o, 16'h5A38 & 16'h3FFF | 16'h4000);
    wr(16'hB005);
    check("R3 upd 11", cfg_o, 16'h9A38);
    wr(16'h1000);
    check("R3 no access started", dac1_o, 16'h07FF);
    check("R3 no access started dac2", dac2_o, 16'h07FF);

    // R4 reserved update code
    wr(16'h2FF2);
    check("R4 cfg unchanged", cfg_o, 16'h1000);
    wr(16'h1000);
    check("R4 no dac write", dac1_o, 16'h07FF);
    check("R4 cfg next", cfg_o, 16'h1000);

    // R6 DAC writes, R10 config untouched by data frame
    wr(16'h1002);
    wr(16'hFABC);
    check("R6 dac1 masked", dac1_o, 16'h02BC);
    check("R10 cfg kept", cfg_o, 16'h1002);
    wr(16'h100A);
    wr(16'h0123);
    check("R6 dac1 alt code", dac1_o, 16'h0123);
    wr(16'h100D);
    wr(16'hF456);
    check("R6 dac2", dac2_o, 16'h0456);
    wr(16'h1000);
    check("R10 back to config", cfg_o, 16'h1000);
    check("R10 dac2 untouched", dac2_o, 16'h0456);

    // R7 sequencer, read-only bits
    wr(16'h1009);
    wr(16'hFFFF);
    check("R7 seq", seq_o, 16'hFFF3);
    // R8 routing
    wr(16'h100C);
    wr(16'hA5C3);
    check("R8 route", route_o, 16'hA5C3);

    // R9 read chain
    frame(16'h1001, W, 1'b1, 1'b1, 16'h0000);
    frame(16'h1003, W, 1'b1, 1'b1, 16'h1001);
    frame(16'h1006, W, 1'b1, 1'b1, 16'h0123);
    frame(16'h100B, W, 1'b1, 1'b1, 16'h0456);
    frame(16'h100E, W, 1'b1, 1'b1, 16'hFFF3);
    frame(16'h1000, W, 1'b1, 1'b1, 16'hA5C3);
    frame(16'h1000, W, 1'b1, 1'b1, 16'h0000);

    // R5 short frames
    wr(16'h1002);
    frame(16'hFFFF, 8, 1'b1, 1'b0, '0);
    check("R5 short 8 bits", dac1_o, 16'h0123);
    frame(16'hFFFF, W, 1'b0, 1'b0, '0);
    check("R5 no final rise", dac1_o, 16'h0123);
    wr(16'h0055);
    check("R5 target kept", dac1_o, 16'h0055);
    frame(16'h5000, W, 1'b0, 1'b0, '0);
    check("R5 cfg unchanged", cfg_o, 16'h1002);

    // R11 software reset
    pulse_cnt = 0;
    wr(16'h1004);
    check("R11 pulse count", 16'(pulse_cnt), 16'd1);
    check("R11 cfg", cfg_o, 16'h0000);
    check("R11 dac1", dac1_o, 16'h07FF);
    check("R11 dac2", dac2_o, 16'h07FF);
    check("R11 seq", seq_o, 16'h0000);
    check("R11 route", route_o, 16'h0000);

    wait_clk(4);
    if (sbq.size() != 0) begin
      checks++; errs++;
      $display("FAIL R9: actual=%0d expected=0 pending items", sbq.size());
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule